// File: doc/BRIEF.md
# Page-Mode Flash Burst Read Controller

This block sits on the host side of an asynchronous NOR flash that has a 4-word page. It turns a burst request (a starting word address and a word count) into read strobes on the flash bus, waits the right number of clocks for each access, and returns every word on a simple valid/data stream. The write strobe is held inactive at all times, because the flash powers up and leaves reset in read mode.

The first word of any page needs the slow random-access time. The block then changes only the two lowest address bits to reach the other words of the same page, and each of those needs only the shorter page-access time. When the word address crosses into the next page, the block applies the long wait again without dropping the strobes. Both wait counts come from parameters for the clock period and the two access times. At the end of a burst the block raises the strobes and spends one clock in a release state before it accepts new work.

A request is a single-cycle pulse on `req_valid`. It is taken only while `busy` is low. A request with a length of zero is dropped.

Top module: `pflash_burst_rd`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, and `busy` and `rd_valid` are 0.
- R2: A request with `req_len` = 0 is ignored. `busy` stays 0 and `fl_ce_n` stays 1.
- R3: `fl_we_n` is always 1. Whenever `fl_oe_n` is 0, `fl_ce_n` is also 0. Both strobes are low for the whole burst, from the accept edge until the last word is sampled.
- R4: The wait counts are derived as ceil(access time / clock period), with a minimum of 1. This gives 14 and 4 clocks for 70 ns and 20 ns at a 5 ns clock.
- R5: The first word of a burst is sampled after the first-access count. `rd_valid` rises that many clocks after the edge that accepted the request.
- R6: Within a page, each later word follows the previous one by the page count. Between those words, `fl_addr` changes only in bits [1:0].
- R7: When the next address has bits [1:0] = 0 (a new page), the first-access count applies again, and `fl_ce_n` and `fl_oe_n` stay 0.
- R8: Exactly `req_len` words are returned, one `rd_valid` pulse each, in ascending address order. Each `rd_data` is the flash word at that address.
- R9: After the last word is sampled, `fl_ce_n` and `fl_oe_n` go to 1 and `busy` stays 1 for one more clock. A request made once `busy` is 0 is accepted.
- R10: A request made while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Burst request pulse |
| req_addr | input | ADDR_W | First word address |
| req_len | input | LEN_W | Number of words, 0 means no burst |
| busy | output | 1 | Burst or bus release in progress |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_addr | output | ADDR_W | Flash word address |
| fl_dq_in | input | DATA_W | Flash data bus |
| rd_valid | output | 1 | Word valid pulse |
| rd_data | output | DATA_W | Returned word |

## Verification
The bench uses the defaults: a 5000 ps clock, 70000 ps and 20000 ps access times, a 22-bit address and an 8-bit length. With these values the wait counts are 14 and 4, so a word sampled even one clock early is caught by the bench's flash model, which returns a wrong value until the access time has passed. Bursts starting at each offset within a page, and bursts that span one or two page boundaries, cover both wait counts and the restart at a page boundary. The 8-bit length covers bursts longer than a page as well as the zero-length case.

// File: rtl/pfr_pkg.sv
// Shared types for the page-mode flash burst reader.
// Assumes: nothing beyond the three-phase control flow below.
package pfr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_READ = 2'd1,
        PH_REL  = 2'd2
    } pfr_phase_t;
endpackage

// File: rtl/pfr_wait_timer.sv
// Down-counter that times one flash access.
// A load sets the number of clocks still to wait minus one; done is high in
// the last clock of the access. Assumes load and run are never high together
// in a way that matters (load wins).
module pfr_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Reload on a new access, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // The count only moves down while it runs without a reload.
    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: rtl/pfr_addr_seq.sv
// Word address and remaining-count tracker for one burst.
// Start loads the first address and length; step moves to the next word.
// Assumes step is never asserted when last is high.
module pfr_addr_seq #(
    parameter int AW = 22,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          page_end
);
    localparam int PG_BITS = 2;

    logic [AW-1:0] addr_q;
    logic [LW-1:0] left_q;

    // Hold the current word address and the number of words still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (start) begin
            addr_q <= start_addr;
            left_q <= start_len;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign addr     = addr_q;
    assign last     = (left_q == LW'(1));
    assign page_end = (addr_q[PG_BITS-1:0] == '1);

    // A step inside a page only changes the in-page bits.
    AST_IN_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && !page_end) |=>
        (addr_q[AW-1:PG_BITS] == $past(addr_q[AW-1:PG_BITS]))); // R6
    // A step at the page end wraps the in-page bits to zero.
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && page_end) |=> (addr_q[PG_BITS-1:0] == '0)); // R7
endmodule

// File: rtl/pflash_burst_rd.sv
// Burst read controller for an asynchronous page-mode NOR flash.
// Accepts a start word address and a length while idle and drives CE/OE low
// for the whole burst. Each page's first word waits FIRST_CYC clocks and each
// other word in the page waits PAGE_CYC clocks; data is registered at the end
// of the wait. A one-clock release phase with strobes high follows every burst.
// Assumes the flash is in read mode and its data bus is synchronous to clk
// after the wait time.
module pflash_burst_rd #(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 8,
    parameter int CLK_PS     = 5000,
    parameter int T_FIRST_PS = 70000,
    parameter int T_PAGE_PS  = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import pfr_pkg::*;

    localparam int FIRST_RAW = (T_FIRST_PS + CLK_PS - 1) / CLK_PS;
    localparam int PAGE_RAW  = (T_PAGE_PS + CLK_PS - 1) / CLK_PS;
    localparam int FIRST_CYC = (FIRST_RAW < 1) ? 1 : FIRST_RAW;
    localparam int PAGE_CYC  = (PAGE_RAW < 1) ? 1 : PAGE_RAW;
    localparam int CNT_W     = $clog2(FIRST_CYC + 1);
    localparam logic [CNT_W-1:0] FIRST_LD = CNT_W'(FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] PAGE_LD  = CNT_W'(PAGE_CYC - 1);

    pfr_phase_t        ph_q;
    logic              take, tmr_done, last, page_end, step, tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] cur_addr;
    logic              word_done;

    assign take      = (ph_q == PH_IDLE) && req_valid && (req_len != '0);
    assign word_done = (ph_q == PH_READ) && tmr_done;
    assign step      = word_done && !last;
    assign tmr_load  = take || step;
    assign tmr_val   = (take || page_end) ? FIRST_LD : PAGE_LD;

    pfr_wait_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (ph_q == PH_READ),
        .done     (tmr_done)
    );

    pfr_addr_seq #(.AW(ADDR_W), .LW(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (take),
        .start_addr (req_addr),
        .start_len  (req_len),
        .step       (step),
        .addr       (cur_addr),
        .last       (last),
        .page_end   (page_end)
    );

    // Phase sequencing: idle, reading, then one release clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= PH_IDLE;
        else begin
            case (ph_q)
                PH_IDLE: if (take) ph_q <= PH_READ;
                PH_READ: if (word_done && last) ph_q <= PH_REL;
                PH_REL:  ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Capture the flash word at the end of each access wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= word_done;
            if (word_done)
                rd_data <= fl_dq_in;
        end
    end

    assign busy    = (ph_q != PH_IDLE);
    assign fl_ce_n = (ph_q != PH_READ);
    assign fl_oe_n = (ph_q != PH_READ);
    assign fl_we_n = 1'b1;
    assign fl_addr = cur_addr;

    // Output enable never active without chip enable, write never active.
    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n |-> !fl_ce_n) && fl_we_n); // R3
    // A returned word always comes from an active read cycle.
    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!fl_ce_n)); // R8
    // Busy drops only after a clock with the strobes released.
    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fl_ce_n && fl_oe_n)); // R9
    // A zero-length request in idle starts nothing.
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_len == '0) |=> !busy); // R2
    // The address stays put while an access is waiting.
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_READ && !tmr_done) |=> $stable(fl_addr)); // R6
endmodule

// File: tb/test_pflash_burst_rd.sv
module test_pflash_burst_rd;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int LW = 8;
    localparam int FC = 14;   // ceil(70 ns / 5 ns)
    localparam int PC = 4;    // ceil(20 ns / 5 ns)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy, fl_ce_n, fl_oe_n, fl_we_n, rd_valid;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_in, rd_data;

    always #2.5 clk = ~clk;

    pflash_burst_rd i_pflash_burst_rd (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_in(fl_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {a[21:16], 10'b0};
    endfunction

    // Flash model: word is correct only once its access time has passed.
    logic          act, m_act;
    logic [AW-1:0] m_addr;
    int            m_cnt, m_need, pres, need;
    assign act = !fl_ce_n && !fl_oe_n && fl_we_n;
    always_comb begin
        if (m_act && act && fl_addr == m_addr) begin
            pres = m_cnt + 1; need = m_need;
        end else if (m_act && act && fl_addr[AW-1:2] == m_addr[AW-1:2] && m_cnt >= m_need) begin
            pres = 1; need = PC;
        end else begin
            pres = 1; need = FC;
        end
        fl_dq_in = (act && pres >= need) ? pat(fl_addr) : 16'hBAD0;
    end
    always @(posedge clk) begin
        m_act  <= act && rst_n;
        m_addr <= fl_addr;
        m_cnt  <= pres;
        m_need <= need;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    int n = 0;
    logic [DW-1:0] got_d [64];
    int            got_c [64];
    logic          got_ce[64];
    logic          got_busy_next[64];
    int            strobe_viol = 0;
    logic          done_flag = 1'b0;

    // Collect returned words and watch strobe rules.
    always @(negedge clk) begin
        if (n > 0 && n <= 64 && got_c[n-1] == cyc - 1) got_busy_next[n-1] = busy;
        if (rd_valid && n < 64) begin
            got_d[n] = rd_data; got_c[n] = cyc; got_ce[n] = fl_ce_n;
            got_busy_next[n] = 1'b1;
            n = n + 1;
        end
        if (rst_n && (!fl_we_n || (!fl_oe_n && fl_ce_n))) strobe_viol = strobe_viol + 1;
    end

    task automatic chk(input logic ok, input string tag, input int act_v, input int exp_v);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [LW-1:0] l, output int c0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l; c0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    endtask

    task automatic verify(input logic [AW-1:0] a, input int l, input int c0);
        int t;
        t = c0 + 1;
        chk(n == l, "R8 word count", n, l);
        for (int i = 0; i < l && i < n; i++) begin
            logic [AW-1:0] ai;
            ai = a + AW'(i);
            if (i == 0) t = t + FC;
            else if (ai[1:0] == 2'b00) t = t + FC;
            else t = t + PC;
            if (i == 0) chk(got_c[i] == t, "R5 first word timing", got_c[i], t);
            else if (ai[1:0] == 2'b00) chk(got_c[i] == t, "R7 page restart timing", got_c[i], t);
            else chk(got_c[i] == t, "R6 in-page timing", got_c[i], t);
            chk(got_d[i] == pat(ai), "R8 data order", got_d[i], pat(ai));
            if (i < l - 1) chk(got_ce[i] == 1'b0, "R7 strobes held low", got_ce[i], 0);
        end
        if (n == l && l > 0) begin
            chk(got_ce[l-1] == 1'b1, "R9 strobes released", got_ce[l-1], 1);
            chk(got_busy_next[l-1] == 1'b0, "R9 busy ends after one release clock",
                got_busy_next[l-1], 0);
        end
    endtask

    task automatic t_burst(input logic [AW-1:0] a, input int l);
        int c0;
        n = 0;
        issue(a, LW'(l), c0);
        wait_idle();
        @(negedge clk);
        verify(a, l, c0);
    endtask

    task automatic t_reset();
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes high", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
        chk(!busy && !rd_valid, "R1 idle outputs", {busy, rd_valid}, 0);
    endtask

    task automatic t_zero_len();
        int c0;
        logic seen;
        n = 0; seen = 1'b0;
        issue(22'h000100, '0, c0);
        for (int k = 0; k < 20; k++) begin
            if (busy || !fl_ce_n) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && n == 0, "R2 zero length ignored", n, 0);
    endtask

    task automatic t_busy_ignore();
        int c0, c1;
        n = 0;
        issue(22'h000041, 8'd3, c0);
        repeat (5) @(negedge clk);
        issue(22'h000200, 8'd5, c1);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(n == 3, "R10 request during busy ignored", n, 3);
        chk(fl_ce_n == 1'b1, "R10 no second burst", fl_ce_n, 1);
        verify(22'h000041, 3, c0);
    endtask

    task automatic t_back_to_back();
        int c0;
        t_burst(22'h000010, 2);
        n = 0;
        issue(22'h000020, 8'd1, c0);
        wait_idle();
        @(negedge clk);
        chk(n == 1, "R9 request after release accepted", n, 1);
        verify(22'h000020, 1, c0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_len();
        t_burst(22'h000000, 4);       // one aligned page
        t_burst(22'h000102, 5);       // crosses one page
        t_burst(22'h000203, 2);       // last word of page then next
        t_burst(22'h000301, 1);       // single word
        t_burst(22'h3FFFF9, 10);      // two crossings
        t_back_to_back();
        t_busy_ignore();
        chk(strobe_viol == 0, "R3 strobe rules", strobe_viol, 0);
        chk(FC == 14 && PC == 4, "R4 wait counts", FC, 14);
        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule